// File: doc/BRIEF.md
# Software Nonvolatile Command Sequence Detector

This block monitors the bus cycles of a battery-free SRAM that has a nonvolatile shadow array. It recognises a fixed run of six chip-enabled read cycles to magic addresses. When the run is complete, it asks a separate controller either to copy the SRAM into the nonvolatile cells (store) or to copy the nonvolatile cells back into the SRAM (recall). The first five addresses of the run are the same for both operations. The sixth address alone decides which operation is requested.

One memory cycle is presented per clock on which `cyc_valid` is high. Only the low 14 address bits take part in matching. Output enable plays no part in recognition. During the cycle that completes a run, `dout_off` tells the data path to leave the bus floating. On the next clock, a one-clock request pulse goes out to the controller.

Top module: `nv_seq_detect`

## Requirements
- R1: A synchronous active-low reset clears the matcher. While reset is held, `store_req`, `recall_req` and `dout_off` are low. A run cut in two by reset is not recognised.
- R2: Six consecutive counted reads at hex 0E38, 31C7, 03E0, 3C1F, 303F, 0FC0 cause `store_req` to be high for exactly one clock. That clock is the one after the sixth cycle's strobe.
- R3: The same five leading addresses followed by hex 0C63 cause `recall_req` to be high for exactly one clock, with the same timing as R2.
- R4: Only `addr[13:0]` is compared with the key values. `addr[14]` has no effect on matching.
- R5: A chip-enabled cycle with `we_n` low anywhere in a run, including at the sixth position, aborts the run. The next step then needs a fresh run, starting from 0E38.
- R6: `oe_n` has no effect on recognition or on any output.
- R7: A chip-enabled read whose address is not the expected key resets the matcher. If that address is 0E38, it counts as the first step of a new run.
- R8: A cycle with `ce_n` high, and any clock with `cyc_valid` low, neither advances nor resets the matcher.
- R9: `dout_off` is high, combinationally, only during a counted read that completes a run (valid, `ce_n` low, `we_n` high, sixth address is a final key). It is low during the five leading reads.
- R10: `store_req` and `recall_req` are never high together. After a request the matcher is idle, so a final key on its own requests nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_valid | input | 1 | High for one clock per memory cycle to be evaluated |
| addr | input | 15 | Memory cycle address |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low (high means read) |
| oe_n | input | 1 | Output enable, active low; ignored |
| store_req | output | 1 | One-clock request to copy SRAM to nonvolatile cells |
| recall_req | output | 1 | One-clock request to copy nonvolatile cells to SRAM |
| dout_off | output | 1 | Data output disable for the completing cycle |

## Verification
Two things can happen in one cycle here: the matcher drops a partial run, and the same address starts a new run. This happens when 0E38 arrives at a step that expects another key. The bench provokes it by sending 0E38 in the fourth slot of a run. It then completes a recall with only five more addresses. A recall pulse in the following clock shows that the restart was taken in the same cycle as the reset. A second coincidence is judged at the completing cycle, where the request must be scheduled and `dout_off` raised together. A write, a deselect or an invalid strobe is placed at that same sixth position, and both outputs must stay low.

// File: rtl/nvsd_pkg.sv
// Package nvsd_pkg
// Shared widths and the magic key values for the nonvolatile command
// sequence detector. Assumes a 15-bit address of which the low 14 bits
// are compared.
package nvsd_pkg;
    localparam int ADDR_W   = 15;
    localparam int KEY_W    = 14;
    localparam int N_PREFIX = 5;

    localparam logic [KEY_W-1:0] STORE_KEY  = 14'h0FC0;
    localparam logic [KEY_W-1:0] RECALL_KEY = 14'h0C63;

    // Returns the key expected at leading step idx (0 = first cycle).
    function automatic logic [KEY_W-1:0] prefix_key(input int idx);
        case (idx)
            0:       return 14'h0E38;
            1:       return 14'h31C7;
            2:       return 14'h03E0;
            3:       return 14'h3C1F;
            default: return 14'h303F;
        endcase
    endfunction
endpackage

// File: rtl/nvsd_addr_cmp.sv
// Module nvsd_addr_cmp
// Compares the key field of the current address against every leading
// key and against both final keys. Purely combinational; assumes the
// caller has already stripped the ignored upper address bits.
module nvsd_addr_cmp
    import nvsd_pkg::*;
#(
    parameter int N_STEP_KEYS = N_PREFIX
) (
    input  logic [KEY_W-1:0]       key_addr,
    output logic [N_STEP_KEYS-1:0] pre_hit,
    output logic                   store_hit,
    output logic                   recall_hit
);
    // One comparator per leading step.
    for (genvar gi = 0; gi < N_STEP_KEYS; gi++) begin : g_pre
        assign pre_hit[gi] = (key_addr == prefix_key(gi));
    end

    // Final-step comparators that choose the operation.
    assign store_hit  = (key_addr == STORE_KEY);
    assign recall_hit = (key_addr == RECALL_KEY);
endmodule

// File: rtl/nvsd_step_fsm.sv
// Module nvsd_step_fsm
// Tracks how many leading keys have matched in order. Counted cycles
// (selected, valid) either advance, restart at step one, or clear the
// count; uncounted cycles leave it untouched. Assumes pre_hit and
// final_hit come from the same cycle as cyc_sel.
module nvsd_step_fsm #(
    parameter int N_PREFIX = 5,
    parameter int STEP_W   = $clog2(N_PREFIX + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cyc_sel,
    input  logic                is_read,
    input  logic [N_PREFIX-1:0] pre_hit,
    input  logic                final_hit,
    output logic [STEP_W-1:0]   step,
    output logic                at_last,
    output logic                fire
);
    localparam int              PAD_W = (1 << STEP_W) - N_PREFIX;
    localparam logic [STEP_W-1:0] LAST  = STEP_W'(N_PREFIX);

    logic [(1<<STEP_W)-1:0] hit_pad;
    logic [STEP_W-1:0]      step_nxt;

    assign hit_pad = {{PAD_W{1'b0}}, pre_hit};
    assign at_last = (step == LAST);
    assign fire    = cyc_sel & is_read & at_last & final_hit;

    // Next-step decision for a counted cycle.
    always_comb begin
        step_nxt = step;
        if (cyc_sel) begin
            if (!is_read) begin
                step_nxt = '0;
            end else if (!at_last && hit_pad[step]) begin
                step_nxt = step + 1'b1;
            end else if (pre_hit[0]) begin
                step_nxt = STEP_W'(1);
            end else begin
                step_nxt = '0;
            end
        end
    end

    // Step register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step <= '0;
        end else begin
            step <= step_nxt;
        end
    end
endmodule

// File: rtl/nvsd_req_gen.sv
// Module nvsd_req_gen
// Turns the completing cycle into one-clock request pulses towards the
// nonvolatile controller. Assumes fire is high for one clock per run.
module nvsd_req_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic store_hit,
    input  logic recall_hit,
    output logic store_req,
    output logic recall_req
);
    // Register the selected request so it appears the clock after.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_req  <= 1'b0;
            recall_req <= 1'b0;
        end else begin
            store_req  <= fire & store_hit;
            recall_req <= fire & recall_hit & ~store_hit;
        end
    end
endmodule

// File: rtl/nv_seq_detect.sv
// Module nv_seq_detect
// Top of the software nonvolatile command sequence detector. Watches
// one memory cycle per cyc_valid strobe, recognises the six-address
// read run and issues store or recall request pulses, plus a data
// output disable during the completing cycle. Assumes one strobe per
// memory cycle and synchronous inputs; output enable is not used.
module nv_seq_detect
    import nvsd_pkg::*;
#(
    parameter int N_STEPS = N_PREFIX + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_valid,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    output logic              store_req,
    output logic              recall_req,
    output logic              dout_off
);
    localparam int N_LEAD = N_STEPS - 1;
    localparam int STEP_W = $clog2(N_STEPS);

    logic [KEY_W-1:0]  key_addr;
    logic [N_LEAD-1:0] pre_hit;
    logic              store_hit;
    logic              recall_hit;
    logic              cyc_sel;
    logic [STEP_W-1:0] step;
    logic              at_last;
    logic              fire;
    logic              unused_inputs;

    assign key_addr      = addr[KEY_W-1:0];
    assign cyc_sel       = cyc_valid & ~ce_n;
    assign unused_inputs = &{1'b0, oe_n, addr[ADDR_W-1:KEY_W]};

    nvsd_addr_cmp #(
        .N_STEP_KEYS (N_LEAD)
    ) cmp_i (
        .key_addr   (key_addr),
        .pre_hit    (pre_hit),
        .store_hit  (store_hit),
        .recall_hit (recall_hit)
    );

    nvsd_step_fsm #(
        .N_PREFIX (N_LEAD),
        .STEP_W   (STEP_W)
    ) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_sel   (cyc_sel),
        .is_read   (we_n),
        .pre_hit   (pre_hit),
        .final_hit (store_hit | recall_hit),
        .step      (step),
        .at_last   (at_last),
        .fire      (fire)
    );

    nvsd_req_gen req_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire       (fire),
        .store_hit  (store_hit),
        .recall_hit (recall_hit),
        .store_req  (store_req),
        .recall_req (recall_req)
    );

    assign dout_off = fire;
endmodule

// File: rtl/nvsd_checker.sv
// Module nvsd_checker
// Concurrent properties for nv_seq_detect, attached with bind. Watches
// ports and the internal step count; drives nothing.
module nvsd_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cyc_valid,
    input logic [14:0] addr,
    input logic        ce_n,
    input logic        we_n,
    input logic [2:0]  step,
    input logic        store_req,
    input logic        recall_req,
    input logic        dout_off
);
    assert_req_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({store_req, recall_req}));

    assert_store_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        store_req |=> !store_req);

    assert_recall_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        recall_req |=> !recall_req);

    assert_store_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
        store_req |-> ($past(dout_off) && $past(addr[13:0]) == 14'h0FC0));

    assert_recall_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
        recall_req |-> ($past(dout_off) && $past(addr[13:0]) == 14'h0C63));

    assert_write_abort_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && !ce_n && !we_n) |=> (step == 3'd0));

    assert_deselect_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_valid || ce_n) |=> $stable(step));

    assert_dout_off_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dout_off |-> (cyc_valid && !ce_n && we_n && step == 3'd5));
endmodule

bind nv_seq_detect nvsd_checker chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cyc_valid  (cyc_valid),
    .addr       (addr),
    .ce_n       (ce_n),
    .we_n       (we_n),
    .step       (step),
    .store_req  (store_req),
    .recall_req (recall_req),
    .dout_off   (dout_off)
);

// File: tb/nv_seq_detect_tb_top.sv
`timescale 1ns/1ps
module nv_seq_detect_tb_top;
    // Vector fields: [25:22] tag, [21] valid, [20] ce_n, [19] we_n,
    // [18] oe_n, [17:3] addr, [2] dout_off, [1] store, [0] recall.
    function automatic logic [25:0] mk(input int tag, input bit v, input bit ce,
                                       input bit we, input bit oe, input logic [14:0] a,
                                       input bit d, input bit s, input bit r);
        logic [3:0] t;
        t = tag[3:0];
        return {t, v, ce, we, oe, a, d, s, r};
    endfunction

    function automatic logic [25:0] rd(input int tag, input logic [14:0] a,
                                       input bit d, input bit s, input bit r);
        return mk(tag, 1'b1, 1'b0, 1'b1, 1'b0, a, d, s, r);
    endfunction

    localparam int N_VEC = 65;
    localparam logic [25:0] VEC [N_VEC] = '{
        // R2 full store run
        rd(2, 15'h0E38, 0, 0, 0), rd(2, 15'h31C7, 0, 0, 0), rd(2, 15'h03E0, 0, 0, 0),
        rd(2, 15'h3C1F, 0, 0, 0), rd(2, 15'h303F, 0, 0, 0), rd(2, 15'h0FC0, 1, 1, 0),
        // R3 recall run with oe_n high throughout (R6)
        mk(6, 1, 0, 1, 1, 15'h0E38, 0, 0, 0), mk(6, 1, 0, 1, 1, 15'h31C7, 0, 0, 0),
        mk(6, 1, 0, 1, 1, 15'h03E0, 0, 0, 0), mk(6, 1, 0, 1, 1, 15'h3C1F, 0, 0, 0),
        mk(6, 1, 0, 1, 1, 15'h303F, 0, 0, 0), mk(3, 1, 0, 1, 1, 15'h0C63, 1, 0, 1),
        // R10 a lone final key after a request
        rd(10, 15'h0FC0, 0, 0, 0),
        // R4 top address bit set on several steps
        rd(4, 15'h4E38, 0, 0, 0), rd(4, 15'h31C7, 0, 0, 0), rd(4, 15'h43E0, 0, 0, 0),
        rd(4, 15'h7C1F, 0, 0, 0), rd(4, 15'h303F, 0, 0, 0), rd(4, 15'h4FC0, 1, 1, 0),
        // R8 deselected and invalid cycles interleaved
        rd(8, 15'h0E38, 0, 0, 0), mk(8, 1, 1, 1, 0, 15'h1234, 0, 0, 0),
        rd(8, 15'h31C7, 0, 0, 0), mk(8, 0, 0, 1, 0, 15'h7777, 0, 0, 0),
        rd(8, 15'h03E0, 0, 0, 0), rd(8, 15'h3C1F, 0, 0, 0),
        mk(8, 1, 1, 0, 0, 15'h0000, 0, 0, 0), rd(8, 15'h303F, 0, 0, 0),
        rd(8, 15'h0FC0, 1, 1, 0),
        // R5 write in the third slot
        rd(5, 15'h0E38, 0, 0, 0), rd(5, 15'h31C7, 0, 0, 0), mk(5, 1, 0, 0, 0, 15'h03E0, 0, 0, 0),
        rd(5, 15'h3C1F, 0, 0, 0), rd(5, 15'h303F, 0, 0, 0), rd(5, 15'h0FC0, 0, 0, 0),
        // R5 write in the sixth slot, then the final key read alone
        rd(5, 15'h0E38, 0, 0, 0), rd(5, 15'h31C7, 0, 0, 0), rd(5, 15'h03E0, 0, 0, 0),
        rd(5, 15'h3C1F, 0, 0, 0), rd(5, 15'h303F, 0, 0, 0), mk(5, 1, 0, 0, 0, 15'h0FC0, 0, 0, 0),
        rd(5, 15'h0FC0, 0, 0, 0),
        // R7 first key arrives at step four: mismatch and restart together
        rd(7, 15'h0E38, 0, 0, 0), rd(7, 15'h31C7, 0, 0, 0), rd(7, 15'h03E0, 0, 0, 0),
        rd(7, 15'h0E38, 0, 0, 0), rd(7, 15'h31C7, 0, 0, 0), rd(7, 15'h03E0, 0, 0, 0),
        rd(7, 15'h3C1F, 0, 0, 0), rd(7, 15'h303F, 0, 0, 0), rd(7, 15'h0C63, 1, 0, 1),
        // R7 wrong sixth address, then a late final key
        rd(7, 15'h0E38, 0, 0, 0), rd(7, 15'h31C7, 0, 0, 0), rd(7, 15'h03E0, 0, 0, 0),
        rd(7, 15'h3C1F, 0, 0, 0), rd(7, 15'h303F, 0, 0, 0), rd(7, 15'h1111, 0, 0, 0),
        rd(7, 15'h0C63, 0, 0, 0),
        // R9 uncounted cycles at the sixth slot keep dout_off low
        rd(9, 15'h0E38, 0, 0, 0), rd(9, 15'h31C7, 0, 0, 0), rd(9, 15'h03E0, 0, 0, 0),
        rd(9, 15'h3C1F, 0, 0, 0), rd(9, 15'h303F, 0, 0, 0), mk(9, 1, 1, 1, 0, 15'h0FC0, 0, 0, 0),
        mk(9, 0, 0, 1, 0, 15'h0FC0, 0, 0, 0), rd(9, 15'h0FC0, 1, 1, 0)
    };

    localparam logic [14:0] KEYS [6] = '{15'h0E38, 15'h31C7, 15'h03E0, 15'h3C1F, 15'h303F, 15'h0FC0};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_valid = 1'b0;
    logic [14:0] addr = '0;
    logic        ce_n = 1'b1;
    logic        we_n = 1'b1;
    logic        oe_n = 1'b0;
    logic        store_req;
    logic        recall_req;
    logic        dout_off;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    nv_seq_detect dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cyc_valid  (cyc_valid),
        .addr       (addr),
        .ce_n       (ce_n),
        .we_n       (we_n),
        .oe_n       (oe_n),
        .store_req  (store_req),
        .recall_req (recall_req),
        .dout_off   (dout_off)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic act, input logic exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
        end
    endtask

    // One memory cycle: drive at negedge, judge dout_off in the same cycle,
    // judge the request pulses just after the following rising edge.
    task automatic drive(input bit v, input bit ce, input bit we, input bit oe,
                         input logic [14:0] a, input bit ed, input bit es,
                         input bit er, input string req);
        @(negedge clk);
        cyc_valid = v; ce_n = ce; we_n = we; oe_n = oe; addr = a;
        #1;
        chk(dout_off === ed, req, "dout_off", dout_off, ed);
        @(posedge clk);
        #1;
        chk(store_req === es, req, "store_req", store_req, es);
        chk(recall_req === er, req, "recall_req", recall_req, er);
    endtask

    task automatic idle();
        @(negedge clk);
        cyc_valid = 1'b0; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b0; addr = '0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        // R1 reset state
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk(store_req === 1'b0, "R1", "store_req in reset", store_req, 1'b0);
        chk(recall_req === 1'b0, "R1", "recall_req in reset", recall_req, 1'b0);
        chk(dout_off === 1'b0, "R1", "dout_off in reset", dout_off, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // Vector table walk
        for (int i = 0; i < N_VEC; i++) begin
            logic [25:0] e;
            string tg;
            e  = VEC[i];
            tg = $sformatf("R%0d vec%0d", e[25:22], i);
            drive(e[21], e[20], e[19], e[18], e[17:3], e[2], e[1], e[0], tg);
        end
        idle();

        // R7 run broken at every step by a foreign address
        for (int k = 0; k < 5; k++) begin
            for (int j = 0; j < k; j++) drive(1, 0, 1, 0, KEYS[j], 0, 0, 0, "R7 break prefix");
            drive(1, 0, 1, 0, 15'h2AAA, 0, 0, 0, "R7 break");
            for (int j = k + 1; j < 6; j++) drive(1, 0, 1, 0, KEYS[j], 0, 0, 0, "R7 break tail");
        end

        // R1 reset in mid-run loses the partial run
        for (int j = 0; j < 3; j++) drive(1, 0, 1, 0, KEYS[j], 0, 0, 0, "R1 before reset");
        @(negedge clk);
        cyc_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int j = 3; j < 6; j++) drive(1, 0, 1, 0, KEYS[j], 0, 0, 0, "R1 after reset");

        // R2 recovery: a clean store run still works
        for (int j = 0; j < 5; j++) drive(1, 0, 1, 0, KEYS[j], 0, 0, 0, "R2 recovery");
        drive(1, 0, 1, 0, KEYS[5], 1, 1, 0, "R2 recovery final");
        drive(0, 1, 1, 0, 15'h0000, 0, 0, 0, "R2 pulse ends");
        idle();

        finish_run();
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(20 * 200000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule